// File: doc/BRIEF.md
# Configuration Access Controller with Readback Lock

This block sits in front of the configuration storage of a small programmable logic array. A host issues one command per cycle over a plain valid/opcode/address/data interface. The commands are:

- write a byte of the fuse map or of the user signature,
- read a byte back for verification,
- force chosen output registers to chosen levels,
- set the security lock,
- erase everything.

The block holds the fuse map, the lock bit and a 64-bit user signature. The signature is seen as eight bytes in an address window of its own.

Once the lock is set, the fuse map can no longer be read, written or used for register preload. The lock applies from the very next command. A locked read returns zero and is flagged. The signature stays readable and writable in either state. The only way back is an erase, which clears the lock together with the fuse map.

Top module: `cfg_access_ctrl`

## Requirements
- R1: After reset `rdValid`, `cmdReject` and `preloadPulse` are low, `preloadValue` is all zeros, the lock is clear and every fuse byte reads 0.
- R2: A write (op 1) to a fuse address 0..FUSE_BYTES-1 stores `cmdData`. A read (op 2) of the same address raises `rdValid` for one cycle on the next clock with that byte on `rdData`.
- R3: Addresses SIG_BASE..SIG_BASE+7 (default 48..55) select signature byte k = address - SIG_BASE for both write and read, separately from the fuse map.
- R4: After a lock command (op 4), any later fuse read still returns `rdValid` high, but with `rdData` = 0 and `cmdReject` high for that one cycle. This holds from the next command onward.
- R5: A fuse write while locked raises `cmdReject` on the next cycle.
- R6: Signature reads and writes work unchanged while locked, with no reject.
- R7: A preload (op 3) while locked raises `cmdReject`, gives no `preloadPulse`, and leaves `preloadValue` unchanged.
- R8: A preload while unlocked sets `preloadValue[i]` to `cmdData[i]` for each bit where `cmdMask[i]` is 1. All other bits keep their value. `preloadPulse` is high for one cycle.
- R9: An erase (op 5) clears the lock and all fuse bytes to 0. The signature is kept.
- R10: An unused opcode (6 or 7), or a read or write to an address in neither window, raises `cmdReject`. Such a read returns `rdData` = 0 with `rdValid` high.
- R11: Every accepted or rejected command gives its response exactly one cycle later, as single-cycle pulses. A no-op (op 0) or an idle cycle gives no `rdValid` and no `cmdReject`. A lock command while already locked is not rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 3 | Opcode: 0 nop, 1 write, 2 read, 3 preload, 4 lock, 5 erase |
| cmdAddr | input | ADDR_W (6) | Byte address (fuse or signature window) |
| cmdData | input | DATA_W (8) | Write data; preload levels |
| cmdMask | input | NUM_REGS (8) | Preload bit select |
| rdValid | output | 1 | Read response strobe |
| rdData | output | DATA_W (8) | Read response byte |
| cmdReject | output | 1 | One-cycle reject flag |
| preloadPulse | output | 1 | Preload applied this cycle |
| preloadValue | output | NUM_REGS (8) | Forced levels for the output registers |

## Verification
The assertions check several properties on every cycle:

- each read command is answered exactly one cycle later and nothing else produces `rdValid`,
- any rejected read carries zero data,
- `preloadValue` moves only together with `preloadPulse`,
- a locked preload is always refused,
- an erase always leaves the lock clear.

Three things are shown only by the bench scenarios, which compare against a reference model of the requirements:

- which byte a given address returns,
- the per-bit effect of the preload mask,
- that the signature survives both locking and erase.

// File: rtl/cfg_access_pkg.sv
package cfg_access_pkg;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_WRITE   = 3'd1,
    OP_READ    = 3'd2,
    OP_PRELOAD = 3'd3,
    OP_LOCK    = 3'd4,
    OP_ERASE   = 3'd5
  } cfg_op_e;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic fuseWr;
    logic fuseRd;
    logic sigWr;
    logic sigRd;
    logic zeroRd;
    logic preload;
    logic erase;
  } cfg_strobe_t;

endpackage

// File: rtl/cfg_access_ctl.sv
module cfg_access_ctl
  import cfg_access_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int FUSE_BYTES = 32,
  parameter int SIG_BASE   = 48,
  parameter int SIG_BYTES  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  output cfg_strobe_t       strobe,
  output logic              lockState,
  output logic              rejectQ
);

  localparam logic [ADDR_W:0] FUSE_LIM = (ADDR_W+1)'(FUSE_BYTES);
  localparam logic [ADDR_W:0] SIG_LO   = (ADDR_W+1)'(SIG_BASE);
  localparam logic [ADDR_W:0] SIG_HI   = (ADDR_W+1)'(SIG_BASE + SIG_BYTES);

  logic [ADDR_W:0] addrExt;
  logic            inFuse;
  logic            inSig;
  logic            rejectNow;
  logic            setLock;
  cfg_op_e         op;

  assign addrExt = {1'b0, cmdAddr};
  assign inFuse  = addrExt < FUSE_LIM;
  assign inSig   = (addrExt >= SIG_LO) && (addrExt < SIG_HI);
  assign op      = cfg_op_e'(cmdOp);

  always_comb begin
    strobe    = '0;
    rejectNow = 1'b0;
    setLock   = 1'b0;
    if (cmdValid) begin
      unique case (op)
        OP_NOP: ;
        OP_WRITE: begin
          if (inSig)                   strobe.sigWr  = 1'b1;
          else if (inFuse && !lockState) strobe.fuseWr = 1'b1;
          else                         rejectNow     = 1'b1;
        end
        OP_READ: begin
          if (inSig)                   strobe.sigRd  = 1'b1;
          else if (inFuse && !lockState) strobe.fuseRd = 1'b1;
          else begin
            strobe.zeroRd = 1'b1;
            rejectNow     = 1'b1;
          end
        end
        OP_PRELOAD: begin
          if (lockState) rejectNow      = 1'b1;
          else           strobe.preload = 1'b1;
        end
        OP_LOCK:  setLock      = 1'b1;
        OP_ERASE: strobe.erase = 1'b1;
        default:  rejectNow    = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lockState <= 1'b0;
      rejectQ   <= 1'b0;
    end else begin
      rejectQ <= rejectNow;
      if (strobe.erase)  lockState <= 1'b0;
      else if (setLock)  lockState <= 1'b1;
    end
  end

endmodule

// File: rtl/cfg_access_store.sv
module cfg_access_store
  import cfg_access_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 8,
  parameter int FUSE_BYTES = 32,
  parameter int SIG_BASE   = 48,
  parameter int SIG_BYTES  = 8,
  parameter int NUM_REGS   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  cfg_strobe_t         strobe,
  input  logic [ADDR_W-1:0]   cmdAddr,
  input  logic [DATA_W-1:0]   cmdData,
  input  logic [NUM_REGS-1:0] cmdMask,
  output logic                rdValid,
  output logic [DATA_W-1:0]   rdData,
  output logic                preloadPulse,
  output logic [NUM_REGS-1:0] preloadValue
);

  logic [DATA_W-1:0] fuseMem [FUSE_BYTES];
  logic [DATA_W-1:0] sigMem  [SIG_BYTES];
  logic [DATA_W-1:0] fuseSel;
  logic [DATA_W-1:0] sigSel;

  for (genvar i = 0; i < FUSE_BYTES; i++) begin : g_fuse
    always_ff @(posedge clk) begin
      if (rst || strobe.erase)
        fuseMem[i] <= '0;
      else if (strobe.fuseWr && cmdAddr == ADDR_W'(i))
        fuseMem[i] <= cmdData;
    end
  end

  for (genvar k = 0; k < SIG_BYTES; k++) begin : g_sig
    always_ff @(posedge clk) begin
      if (rst)
        sigMem[k] <= '0;
      else if (strobe.sigWr && cmdAddr == ADDR_W'(SIG_BASE + k))
        sigMem[k] <= cmdData;
    end
  end

  always_comb begin
    fuseSel = '0;
    for (int i = 0; i < FUSE_BYTES; i++)
      if (cmdAddr == ADDR_W'(i)) fuseSel = fuseMem[i];
    sigSel = '0;
    for (int k = 0; k < SIG_BYTES; k++)
      if (cmdAddr == ADDR_W'(SIG_BASE + k)) sigSel = sigMem[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobe.fuseRd | strobe.sigRd | strobe.zeroRd;
      if (strobe.fuseRd)     rdData <= fuseSel;
      else if (strobe.sigRd) rdData <= sigSel;
      else                   rdData <= '0;
    end
  end

  for (genvar b = 0; b < NUM_REGS; b++) begin : g_pl
    always_ff @(posedge clk) begin
      if (rst)
        preloadValue[b] <= 1'b0;
      else if (strobe.preload && cmdMask[b])
        preloadValue[b] <= cmdData[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) preloadPulse <= 1'b0;
    else     preloadPulse <= strobe.preload;
  end

endmodule

// File: rtl/cfg_access_ctrl.sv
module cfg_access_ctrl
  import cfg_access_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 8,
  parameter int FUSE_BYTES = 32,
  parameter int SIG_BASE   = 48,
  parameter int SIG_BYTES  = 8,
  parameter int NUM_REGS   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmdValid,
  input  logic [2:0]          cmdOp,
  input  logic [ADDR_W-1:0]   cmdAddr,
  input  logic [DATA_W-1:0]   cmdData,
  input  logic [NUM_REGS-1:0] cmdMask,
  output logic                rdValid,
  output logic [DATA_W-1:0]   rdData,
  output logic                cmdReject,
  output logic                preloadPulse,
  output logic [NUM_REGS-1:0] preloadValue
);

  cfg_strobe_t strobe;
  logic        lockState;

  cfg_access_ctl #(
    .ADDR_W(ADDR_W), .FUSE_BYTES(FUSE_BYTES),
    .SIG_BASE(SIG_BASE), .SIG_BYTES(SIG_BYTES)
  ) u_ctl (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .strobe(strobe), .lockState(lockState),
    .rejectQ(cmdReject)
  );

  cfg_access_store #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FUSE_BYTES(FUSE_BYTES),
    .SIG_BASE(SIG_BASE), .SIG_BYTES(SIG_BYTES), .NUM_REGS(NUM_REGS)
  ) u_store (
    .clk(clk), .rst(rst), .strobe(strobe), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .cmdMask(cmdMask), .rdValid(rdValid),
    .rdData(rdData), .preloadPulse(preloadPulse),
    .preloadValue(preloadValue)
  );

endmodule

// File: rtl/cfg_access_chk.sv
module cfg_access_chk #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                cmdValid,
  input logic [2:0]          cmdOp,
  input logic                rdValid,
  input logic [DATA_W-1:0]   rdData,
  input logic                cmdReject,
  input logic                preloadPulse,
  input logic [NUM_REGS-1:0] preloadValue,
  input logic                lockState
);

  // R11: every read is answered one cycle later
  p_read_answered_r11: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdOp == 3'd2) |=> rdValid);

  // R11: no read strobe without a read command
  p_no_spurious_read_r11: assert property (@(posedge clk) disable iff (rst)
    !(cmdValid && cmdOp == 3'd2) |=> !rdValid);

  // R4 / R10: rejected reads carry zero
  p_reject_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (rdValid && cmdReject) |-> rdData == '0);

  // R8: preload value moves only with the pulse
  p_preload_only_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    !preloadPulse |-> $stable(preloadValue));

  // R7: locked preload is refused
  p_locked_preload_r7: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdOp == 3'd3 && lockState) |=> (cmdReject && !preloadPulse));

  // R9: erase always leaves the lock clear
  p_erase_unlocks_r9: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdOp == 3'd5) |=> !lockState);

endmodule

bind cfg_access_ctrl cfg_access_chk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .rdValid(rdValid), .rdData(rdData), .cmdReject(cmdReject),
  .preloadPulse(preloadPulse), .preloadValue(preloadValue),
  .lockState(lockState)
);

// File: tb/cfg_access_ctrl_tb.sv
`timescale 1ns/1ps
module cfg_access_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmdValid = 1'b0;
  logic [2:0] cmdOp = '0;
  logic [5:0] cmdAddr = '0;
  logic [7:0] cmdData = '0;
  logic [7:0] cmdMask = '0;
  logic       rdValid;
  logic [7:0] rdData;
  logic       cmdReject;
  logic       preloadPulse;
  logic [7:0] preloadValue;

  always #2.5 clk = ~clk;

  cfg_access_ctrl u_dut (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .cmdMask(cmdMask),
    .rdValid(rdValid), .rdData(rdData), .cmdReject(cmdReject),
    .preloadPulse(preloadPulse), .preloadValue(preloadValue)
  );

  typedef struct {
    logic       rd;
    logic [7:0] data;
    logic       rej;
    logic       pl;
    logic [7:0] plv;
    string      req;
  } exp_t;

  exp_t expQ[$];
  int   checks = 0;
  int   errors = 0;

  // reference model of the requirements
  logic [7:0] fuseM [32];
  logic [7:0] sigM  [8];
  logic       lockM = 1'b0;
  logic [7:0] plM   = '0;

  task automatic doCmd(input logic [2:0] op, input logic [5:0] addr,
                       input logic [7:0] data, input logic [7:0] mask,
                       input string req);
    exp_t e;
    bit inF, inS;
    e.rd = 0; e.data = 0; e.rej = 0; e.pl = 0; e.req = req;
    inF = addr < 32;
    inS = addr >= 48 && addr < 56;
    case (op)
      3'd0: ;
      3'd1: if (inS) sigM[addr-48] = data;
            else if (inF && !lockM) fuseM[addr] = data;
            else e.rej = 1;
      3'd2: begin
        e.rd = 1;
        if (inS) e.data = sigM[addr-48];
        else if (inF && !lockM) e.data = fuseM[addr];
        else e.rej = 1;
      end
      3'd3: if (lockM) e.rej = 1;
            else begin
              e.pl = 1;
              plM = (plM & ~mask) | (data & mask);
            end
      3'd4: lockM = 1;
      3'd5: begin
        lockM = 0;
        for (int i = 0; i < 32; i++) fuseM[i] = '0;
      end
      default: e.rej = 1;
    endcase
    e.plv = plM;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = addr; cmdData = data; cmdMask = mask;
    expQ.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = '0;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        checks++;
        if (rdValid !== e.rd || (e.rd && rdData !== e.data) || cmdReject !== e.rej ||
            preloadPulse !== e.pl || preloadValue !== e.plv) begin
          errors++;
          $display("FAIL %s: got rd=%b data=%h rej=%b pl=%b plv=%h exp rd=%b data=%h rej=%b pl=%b plv=%h",
                   e.req, rdValid, rdData, cmdReject, preloadPulse, preloadValue,
                   e.rd, e.data, e.rej, e.pl, e.plv);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) fuseM[i] = '0;
    for (int k = 0; k < 8; k++) sigM[k] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (rdValid !== 0 || cmdReject !== 0 || preloadPulse !== 0 || preloadValue !== 0) begin
      errors++;
      $display("FAIL R1: got rd=%b rej=%b pl=%b plv=%h exp 0 0 0 00",
               rdValid, cmdReject, preloadPulse, preloadValue);
    end
    doCmd(3'd2, 6'd5, 8'h00, 8'h00, "R1");
    doCmd(3'd1, 6'd3, 8'hA5, 8'h00, "R2");
    doCmd(3'd2, 6'd3, 8'h00, 8'h00, "R2");
    doCmd(3'd1, 6'd31, 8'h3C, 8'h00, "R2");
    doCmd(3'd2, 6'd31, 8'h00, 8'h00, "R2");
    doCmd(3'd0, 6'd31, 8'h00, 8'h00, "R11");
    doCmd(3'd1, 6'd48, 8'h11, 8'h00, "R3");
    doCmd(3'd1, 6'd55, 8'hEE, 8'h00, "R3");
    doCmd(3'd2, 6'd48, 8'h00, 8'h00, "R3");
    doCmd(3'd2, 6'd55, 8'h00, 8'h00, "R3");
    doCmd(3'd2, 6'd3, 8'h00, 8'h00, "R3");
    doCmd(3'd3, 6'd0, 8'h0F, 8'hFF, "R8");
    doCmd(3'd3, 6'd0, 8'hFF, 8'h30, "R8");
    doCmd(3'd3, 6'd0, 8'h00, 8'h01, "R8");
    doCmd(3'd2, 6'd40, 8'h00, 8'h00, "R10");
    doCmd(3'd1, 6'd56, 8'h99, 8'h00, "R10");
    doCmd(3'd7, 6'd0, 8'h00, 8'h00, "R10");
    doCmd(3'd6, 6'd0, 8'h00, 8'h00, "R10");
    idle();
    doCmd(3'd4, 6'd0, 8'h00, 8'h00, "R4");
    doCmd(3'd2, 6'd3, 8'h00, 8'h00, "R4");
    doCmd(3'd2, 6'd31, 8'h00, 8'h00, "R4");
    doCmd(3'd1, 6'd3, 8'h77, 8'h00, "R5");
    doCmd(3'd3, 6'd0, 8'hFF, 8'hFF, "R7");
    doCmd(3'd2, 6'd48, 8'h00, 8'h00, "R6");
    doCmd(3'd1, 6'd49, 8'h77, 8'h00, "R6");
    doCmd(3'd2, 6'd49, 8'h00, 8'h00, "R6");
    doCmd(3'd4, 6'd0, 8'h00, 8'h00, "R11");
    doCmd(3'd5, 6'd0, 8'h00, 8'h00, "R9");
    doCmd(3'd2, 6'd3, 8'h00, 8'h00, "R9");
    doCmd(3'd2, 6'd31, 8'h00, 8'h00, "R9");
    doCmd(3'd2, 6'd48, 8'h00, 8'h00, "R9");
    doCmd(3'd1, 6'd3, 8'h5A, 8'h00, "R9");
    doCmd(3'd2, 6'd3, 8'h00, 8'h00, "R9");
    doCmd(3'd3, 6'd0, 8'hA0, 8'hF0, "R8");
    idle();
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule